// File: doc/BRIEF.md
# Fixed-Frequency Peak-Current PWM Controller

This block produces the high-side switch command for a synchronous buck power stage run under constant-frequency peak-current control. A free-running tick counter defines each switching period. When a period begins the high-side command goes high. It drops when an external comparator reports that the inductor current has reached its limit, with two exceptions. A trip that comes too early is held off until a minimum on-time has passed. If no trip has come by the duty ceiling, the command is forced off.

The period and the minimum on-time are given in system-clock ticks on plain control inputs. They are sampled only when a new period starts. The duty ceiling is derived from the sampled period at the same moment. The current-trip input is asynchronous. It passes through a synchronizer, and only its first rising edge in a period counts. Two single-cycle strobes mark the start of each period and each accepted trip, for the dead-time logic that follows. There are no data streams here, so every pin is a plain level or strobe with no handshake.

Top module: `pcm_pwm_core`

## Requirements
- R1: While `en` is high, `cyc_start` pulses for exactly one clock at the start of each period. `top_on` is high in that same cycle. Consecutive `cyc_start` pulses are P clocks apart, where P is the period in force.
- R2: The sampled `period_ticks` value is clamped to the range 260..800 ticks. With a 200 MHz clock this spans about 250 kHz to 770 kHz.
- R3: `period_ticks` and `min_on_ticks` are sampled only at the clock edge that starts a period. A change in mid-period affects only the next period.
- R4: `trip_in` passes through a two-flop synchronizer followed by an edge detector. If `trip_in` first becomes high just after the edge that leaves the counter at tick a (tick 0 is the `cyc_start` cycle), the on-time becomes a+3 clocks, unless R5 or R6 applies.
- R5: A trip that would give an on-time shorter than the sampled minimum is held pending. `top_on` then falls after exactly the minimum number of clocks. A minimum larger than the duty ceiling is reduced to the ceiling.
- R6: The duty ceiling is floor(P*243/256) clocks, roughly 95 %. If no trip has been accepted by then, `top_on` is forced low at the ceiling and `trip_ack` stays low. A trip whose a+3 equals the ceiling still counts as a trip.
- R7: Only the first rising edge of the synchronized trip in a period is acted on. Later edges, including edges that come after a forced turn-off, are ignored. Once low, `top_on` stays low until the next `cyc_start`.
- R8: `trip_ack` is a one-clock strobe. It is high in the first low cycle of `top_on` after a turn-off caused by a trip. It never coincides with `cyc_start`.
- R9: While `en` is low, `top_on`, `cyc_start` and `trip_ack` are low from the next edge on. Trips are ignored. The first edge with `en` high again starts a new period.
- R10: During reset (`rst_n` low, asynchronous) all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous enable for switching |
| period_ticks | input | CNT_W | Switching period in clock ticks, sampled at period start |
| min_on_ticks | input | CNT_W | Minimum on-time in clock ticks, sampled at period start |
| trip_in | input | 1 | Asynchronous peak-current trip from the comparator |
| top_on | output | 1 | High-side switch on command |
| cyc_start | output | 1 | One-clock strobe at the start of each period |
| trip_ack | output | 1 | One-clock strobe for an accepted trip turn-off |

## Verification
The bench aims at the borders between the three ways a period can end. It drives a trip early enough to be pended by the blanking window, a trip whose on-time lands exactly on the duty ceiling, and a trip one beat too late. A design with the comparison off by one would either report the exact-ceiling trip as a forced turn-off or miss the ceiling by a clock. It changes the period in mid-period, and it drives periods outside the allowed range. A design that samples continuously or skips the clamp would produce period lengths and ceilings the scoreboard rejects. It also sends second trip edges, both while a trip is pending and after turn-off, and it pulls enable low while the switch is on. A design without first-edge gating, or one that lets enable lag, would re-arm the switch or leak strobes.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_PEND = 2'd2,
    PH_DONE = 2'd3
  } ph_e;
endpackage

// File: rtl/pcm_trip_sync.sv
module pcm_trip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[0] <= 1'b0;
        else        sh_q[0] <= trip_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[g] <= 1'b0;
        else        sh_q[g] <= sh_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sh_q[STAGES-1];
  end

  assign rise_o = sh_q[STAGES-1] & ~last_q;

  // R4: a detected rise lasts a single cycle
  a_r4_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pcm_period_timer.sv
module pcm_period_timer #(
  parameter int CNT_W      = 12,
  parameter int PER_MIN    = 260,
  parameter int PER_MAX    = 800,
  parameter int DUTY_NUM   = 243,
  parameter int DUTY_SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] min_i,
  output logic             new_cyc_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] min_o,
  output logic [CNT_W-1:0] max_o
);
  localparam int PROD_W = CNT_W + DUTY_SHIFT;
  localparam logic [CNT_W-1:0] PMIN = CNT_W'(PER_MIN);
  localparam logic [CNT_W-1:0] PMAX = CNT_W'(PER_MAX);

  logic              run_q;
  logic [CNT_W-1:0]  cnt_q, per_q, min_q, max_q;
  logic [CNT_W-1:0]  per_c, max_nx, min_nx;
  logic [PROD_W-1:0] prod;

  always_comb begin
    if (per_i < PMIN)      per_c = PMIN;
    else if (per_i > PMAX) per_c = PMAX;
    else                   per_c = per_i;
    prod   = PROD_W'(per_c) * PROD_W'(DUTY_NUM);
    max_nx = prod[PROD_W-1:DUTY_SHIFT];
    min_nx = (min_i > max_nx) ? max_nx : min_i;
  end

  assign new_cyc_o = en && (!run_q || (cnt_q == per_q - CNT_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      per_q <= PMIN;
      min_q <= '0;
      max_q <= '0;
    end else if (!en) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (new_cyc_o) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      per_q <= per_c;
      min_q <= min_nx;
      max_q <= max_nx;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign min_o = min_q;
  assign max_o = max_q;

  // R1: the counter never runs past the period in force
  a_r1_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < per_q));
  // R2: the period in force is within the allowed range
  a_r2_period_range: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (per_q >= PMIN && per_q <= PMAX));
  // R3: sampled limits hold steady inside a period
  a_r3_limits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en && !new_cyc_o) |=> ($stable(min_q) && $stable(max_q) && $stable(per_q)));
  // R5: the minimum never exceeds the ceiling
  a_r5_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (min_q <= max_q));
endmodule

// File: rtl/pcm_ontime_ctrl.sv
module pcm_ontime_ctrl
  import pcm_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             new_cyc_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] min_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             trip_rise_i,
  output logic             top_on_o,
  output logic             start_o,
  output logic             trip_o
);
  ph_e          ph_q, ph_d;
  logic         top_q, top_d, start_q, start_d, trip_q, trip_d;
  logic [CNT_W:0] cnt_nx, min_x, max_x;

  assign cnt_nx = {1'b0, cnt_i} + (CNT_W+1)'(1);
  assign min_x  = {1'b0, min_i};
  assign max_x  = {1'b0, max_i};

  always_comb begin
    ph_d    = ph_q;
    top_d   = top_q;
    start_d = 1'b0;
    trip_d  = 1'b0;
    if (!en) begin
      ph_d  = PH_IDLE;
      top_d = 1'b0;
    end else if (new_cyc_i) begin
      ph_d    = PH_ON;
      top_d   = 1'b1;
      start_d = 1'b1;
    end else begin
      unique case (ph_q)
        PH_ON: begin
          if (trip_rise_i) begin
            if (cnt_nx >= min_x) begin
              top_d  = 1'b0;
              trip_d = 1'b1;
              ph_d   = PH_DONE;
            end else begin
              ph_d = PH_PEND;
            end
          end else if (cnt_nx >= max_x) begin
            top_d = 1'b0;
            ph_d  = PH_DONE;
          end
        end
        PH_PEND: begin
          if (cnt_nx >= min_x || cnt_nx >= max_x) begin
            top_d  = 1'b0;
            trip_d = 1'b1;
            ph_d   = PH_DONE;
          end
        end
        default: begin
          top_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      top_q   <= 1'b0;
      start_q <= 1'b0;
      trip_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      top_q   <= top_d;
      start_q <= start_d;
      trip_q  <= trip_d;
    end
  end

  assign top_on_o = top_q;
  assign start_o  = start_q;
  assign trip_o   = trip_q;

  // R1: a period start always comes with the switch on
  a_r1_start_with_top: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> top_on_o);
  // R8: accepted trip coincides with the falling command
  a_r8_trip_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> (!top_on_o && $past(top_on_o)));
  // R8: strobes never overlap
  a_r8_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, trip_o}));
  // R9: disable forces everything low on the next edge
  a_r9_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!top_on_o && !start_o && !trip_o));
  // R5, R6: every turn-off while enabled falls inside the on-time window
  a_r5_on_window: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $fell(top_on_o)) |-> (cnt_i >= min_i && cnt_i <= max_i));
  // R7: once off, the command stays off until a new period
  a_r7_stay_low: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DONE && en && !new_cyc_i) |=> !top_on_o);
endmodule

// File: rtl/pcm_pwm_core.sv
module pcm_pwm_core #(
  parameter int CNT_W       = 12,
  parameter int PER_MIN     = 260,
  parameter int PER_MAX     = 800,
  parameter int DUTY_NUM    = 243,
  parameter int DUTY_SHIFT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_ticks,
  input  logic [CNT_W-1:0] min_on_ticks,
  input  logic             trip_in,
  output logic             top_on,
  output logic             cyc_start,
  output logic             trip_ack
);
  logic             new_cyc, trip_rise;
  logic [CNT_W-1:0] cnt, min_lim, max_lim;

  pcm_trip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .trip_i (trip_in),
    .rise_o (trip_rise)
  );

  pcm_period_timer #(
    .CNT_W(CNT_W), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX),
    .DUTY_NUM(DUTY_NUM), .DUTY_SHIFT(DUTY_SHIFT)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .per_i     (period_ticks),
    .min_i     (min_on_ticks),
    .new_cyc_o (new_cyc),
    .cnt_o     (cnt),
    .min_o     (min_lim),
    .max_o     (max_lim)
  );

  pcm_ontime_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .new_cyc_i   (new_cyc),
    .cnt_i       (cnt),
    .min_i       (min_lim),
    .max_i       (max_lim),
    .trip_rise_i (trip_rise),
    .top_on_o    (top_on),
    .start_o     (cyc_start),
    .trip_o      (trip_ack)
  );
endmodule

// File: tb/sim_pcm_pwm_core.sv
`timescale 1ns/1ps
module sim_pcm_pwm_core;
  localparam int CW = 12;
  localparam int NS = 11;

  typedef struct {
    int per;
    int on;
    int trp;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [CW-1:0] period_ticks = 12'd400;
  logic [CW-1:0] min_on_ticks = 12'd18;
  logic          trip_in = 1'b0;
  logic          top_on, cyc_start, trip_ack;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t exp_q[$];
  bit mon_active = 1'b0;
  bit meas = 1'b0;
  int per_cnt, on_cnt, trip_seen;
  bit prev_top = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcm_pwm_core u0 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .period_ticks(period_ticks), .min_on_ticks(min_on_ticks),
    .trip_in(trip_in), .top_on(top_on), .cyc_start(cyc_start), .trip_ack(trip_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic exp_t model(input int per, input int mn, input int ta);
    exp_t e;
    int pc, mx, mc, t;
    pc = (per < 260) ? 260 : ((per > 800) ? 800 : per);
    mx = (pc * 243) >> 8;
    mc = (mn > mx) ? mx : mn;
    e.per = pc;
    if (ta < 0) begin
      e.on = mx; e.trp = 0;
    end else begin
      t = ta + 3;
      if (t <= mx) begin
        e.trp = 1; e.on = (t > mc) ? t : mc;
      end else begin
        e.trp = 0; e.on = mx;
      end
    end
    return e;
  endfunction

  // Monitor: measures each period and compares with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mon_active) begin
      if (cyc_start) begin
        if (meas) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1 scoreboard empty", 0, 1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(per_cnt == e.per, "R1/R2/R3 period length", per_cnt, e.per);
            chk(on_cnt == e.on, "R4/R5/R6 on-time", on_cnt, e.on);
            chk(trip_seen == e.trp, "R6/R8 trip strobe count", trip_seen, e.trp);
          end
        end
        chk(top_on == 1'b1, "R1 top on at start", top_on, 1);
        meas = 1'b1;
        per_cnt = 1;
        on_cnt = top_on ? 1 : 0;
        trip_seen = 0;
      end else if (meas) begin
        per_cnt++;
        if (top_on) on_cnt++;
        if (top_on && !prev_top) chk(1'b0, "R7 top re-rose mid-period", 1, 0);
        if (trip_ack) begin
          trip_seen++;
          chk(!top_on && prev_top, "R8 strobe on fall", top_on, 0);
        end
      end
    end
    prev_top = top_on;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  int per_a[NS];
  int mn_a[NS];
  int ta_a[NS];
  int t2_a[NS];

  initial begin
    // scenarios: period, minimum, trip tick (-1 none), second trip tick (-1 none)
    per_a = '{400, 400, 400, 300, 300, 100, 2000, 500, 500, 260, 400};
    mn_a  = '{18,  18,  18,  18,  18,  18,  18,   40,  40,  300, 0};
    ta_a  = '{100, 5,   -1,  285, 281, 50,  400,  60,  2,   0,   0};
    t2_a  = '{-1,  -1,  -1,  -1,  -1,  -1,  -1,   120, 20,  -1,  -1};

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(top_on == 0 && cyc_start == 0 && trip_ack == 0, "R10 reset outputs",
        {top_on, cyc_start, trip_ack}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(top_on == 0 && cyc_start == 0, "R9 idle while disabled", {top_on, cyc_start}, 0);

    period_ticks = CW'(per_a[0]);
    min_on_ticks = CW'(mn_a[0]);
    mon_active = 1'b1;
    en = 1'b1;

    for (int i = 0; i < NS; i++) begin
      int pos;
      do @(negedge clk); while (!cyc_start);
      pos = 0;
      // R3: next period values applied mid-period
      if (i + 1 < NS) begin
        period_ticks = CW'(per_a[i+1]);
        min_on_ticks = CW'(mn_a[i+1]);
      end
      exp_q.push_back(model(per_a[i], mn_a[i], ta_a[i]));
      if (ta_a[i] >= 0) begin
        while (pos < ta_a[i]) begin @(negedge clk); pos++; end
        trip_in = 1'b1;
        repeat (4) begin @(negedge clk); pos++; end
        trip_in = 1'b0;
        if (t2_a[i] >= 0) begin
          // R7: second edge in the same period
          while (pos < t2_a[i]) begin @(negedge clk); pos++; end
          trip_in = 1'b1;
          repeat (4) begin @(negedge clk); pos++; end
          trip_in = 1'b0;
        end
      end
    end
    do @(negedge clk); while (!cyc_start);
    #1 mon_active = 1'b0;
    chk(exp_q.size() == 0, "R1 all periods compared", exp_q.size(), 0);

    // R9: disable while the switch is on
    repeat (10) @(negedge clk);
    chk(top_on == 1'b1, "R9 switch on before disable", top_on, 1);
    en = 1'b0;
    @(negedge clk);
    chk(top_on == 1'b0 && cyc_start == 0 && trip_ack == 0, "R9 off after disable", top_on, 0);
    begin
      int leaks;
      leaks = 0;
      for (int k = 0; k < 40; k++) begin
        trip_in = (k >= 5 && k < 10);
        @(negedge clk);
        if (top_on || cyc_start || trip_ack) leaks++;
      end
      chk(leaks == 0, "R9 quiet while disabled", leaks, 0);
    end
    en = 1'b1;
    @(negedge clk);
    chk(cyc_start == 1'b1 && top_on == 1'b1, "R9 restart on enable", {cyc_start, top_on}, 3);
    @(negedge clk);
    chk(cyc_start == 1'b0, "R1 start strobe single cycle", cyc_start, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule